// File: doc/BRIEF.md
# FIFO Threshold Offset Loader

This block stores the two thresholds that a FIFO's partial flags compare against: the almost-empty distance and the almost-full distance. Each threshold is wider than the FIFO data port, so each one is split into a low part and a high part. That gives four narrow sub-registers. Software writes them, and later reads them back, through the FIFO's own data path.

A load pin and the write or read enable decide what each clock edge does. An edge either accesses a sub-register or passes through as a normal FIFO access. Register accesses walk a pointer through a fixed cycle of four steps: almost-empty low part, almost-empty high part, almost-full low part, almost-full high part, then back to the start. The write side and the read side each have their own pointer in their own clock domain.

The load pin is captured while reset is asserted. If it is high at that point, register access is switched off until the next reset, and every enabled edge becomes a FIFO access. The assembled thresholds come out on two ports for the flag logic. The storage array and the flag comparators are not part of this block.

Top module: `offset_loader`

## Requirements
- R1: While reset is asserted and right after it, both thresholds read 7, `rd_data` is 0 and `rd_valid` is 0.
- R2: With register access enabled, `ld`=0 and `wr_en_n`=0, each rising `wr_clk` edge stores `wr_data` into the current sub-register and moves the write pointer on. The order is: almost-empty low (code 0), almost-empty high (code 1), almost-full low (code 2), almost-full high (code 3).
- R3: After the almost-full high part, the next register write goes to the almost-empty low part again.
- R4: With `ld`=0 and `wr_en_n`=1, a write-clock edge changes neither threshold nor the write pointer.
- R5: With `ld`=1 and `wr_en_n`=0, `fifo_wr` is 1, the thresholds are unchanged and the write pointer stays where it was.
- R6: A low part holds `wr_data[8:0]` as threshold bits [8:0]. A high part holds `wr_data[4:0]` as threshold bits [13:9]. Bits [8:5] are ignored on a high-part write and read back as 0.
- R7: With register access enabled, `ld`=0 and `rd_en_n`=0, each rising `rd_clk` edge puts the current sub-register on `rd_data`, pulses `rd_valid` for one cycle and moves the read pointer on. The read pointer follows the same four-step cycle, including the wrap.
- R8: With `ld`=1 and `rd_en_n`=0, `fifo_rd` is 1, `rd_valid` stays 0 and the read pointer does not move.
- R9: If `ld` is 1 while reset is asserted, register access is off until the next reset. Every write enable then drives `fifo_wr`, every read enable drives `fifo_rd`, and the thresholds keep their values.
- R10: A reset partway through a load returns both pointers to the almost-empty low part and both thresholds to 7.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wr_clk | input | 1 | Write-side clock |
| rd_clk | input | 1 | Read-side clock |
| rst | input | 1 | Synchronous active-high reset, seen in both domains |
| ld | input | 1 | Load select: 0 = sub-register access, 1 = FIFO access |
| wr_en_n | input | 1 | Write enable, active low |
| wr_data | input | DATA_W | Write data bus |
| rd_en_n | input | 1 | Read enable, active low |
| rd_data | output | DATA_W | Registered read-back data |
| rd_valid | output | 1 | One-cycle pulse when `rd_data` carries a fresh read-back |
| fifo_wr | output | 1 | The current write edge is a FIFO write |
| fifo_rd | output | 1 | The current read edge is a FIFO read |
| empty_ofs | output | OFS_W | Assembled almost-empty threshold |
| full_ofs | output | OFS_W | Assembled almost-full threshold |

## Verification
The thresholds are loaded with distinct values in the four sub-registers, so a value landing in the wrong place shows up on the assembled outputs. Idle edges and FIFO-directed edges are placed in the middle of a load sequence. The next register write then reveals whether the pointer moved when it should not have. High-part data is given with its upper bus bits set, which separates truncation from pass-through in both storage and read-back. A mid-sequence reset and a reset with `ld` high check that the pointer returns to the start and that the access mode is captured only at reset.

// File: rtl/ofsld_pkg.sv
package ofsld_pkg;

  typedef enum logic [1:0] {
    SEL_E_LO = 2'd0,
    SEL_E_HI = 2'd1,
    SEL_F_LO = 2'd2,
    SEL_F_HI = 2'd3
  } sub_sel_e;

  localparam int NUM_OFS = 2;

  function automatic sub_sel_e sel_next(sub_sel_e s);
    logic [1:0] v;
    if (s == SEL_F_HI) return SEL_E_LO;
    v = s;
    v = v + 2'd1;
    return sub_sel_e'(v);
  endfunction

endpackage

// File: rtl/ofsld_cycler.sv
module ofsld_cycler
  import ofsld_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     step,
  output sub_sel_e sel
);

  always_ff @(posedge clk) begin
    if (rst) sel <= SEL_E_LO;
    else if (step) sel <= sel_next(sel);
  end

endmodule

// File: rtl/ofsld_regbank.sv
module ofsld_regbank
  import ofsld_pkg::*;
#(
  parameter int DATA_W  = 9,
  parameter int OFS_W   = 14,
  parameter int DEF_OFS = 7
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             wr,
  input  sub_sel_e                         sel,
  input  logic [DATA_W-1:0]                din,
  output logic [NUM_OFS-1:0][DATA_W-1:0]   sub_lo,
  output logic [NUM_OFS-1:0][OFS_W-DATA_W-1:0] sub_hi,
  output logic [OFS_W-1:0]                 empty_ofs,
  output logic [OFS_W-1:0]                 full_ofs
);

  localparam int LO_W = DATA_W;
  localparam int HI_W = OFS_W - DATA_W;
  localparam logic [OFS_W-1:0] DEF = OFS_W'(DEF_OFS);

  logic [1:0] sel_v;
  assign sel_v = sel;

  for (genvar g = 0; g < NUM_OFS; g++) begin : g_ofs
    localparam logic [1:0] LO_CODE = 2'(2 * g);
    localparam logic [1:0] HI_CODE = 2'(2 * g + 1);

    always_ff @(posedge clk) begin
      if (rst) begin
        sub_lo[g] <= DEF[LO_W-1:0];
        sub_hi[g] <= DEF[OFS_W-1:LO_W];
      end else if (wr) begin
        if (sel_v == LO_CODE) sub_lo[g] <= din;
        if (sel_v == HI_CODE) sub_hi[g] <= din[HI_W-1:0];
      end
    end
  end

  assign empty_ofs = {sub_hi[0], sub_lo[0]};
  assign full_ofs  = {sub_hi[1], sub_lo[1]};

endmodule

// File: rtl/ofsld_readback.sv
module ofsld_readback
  import ofsld_pkg::*;
#(
  parameter int DATA_W = 9,
  parameter int OFS_W  = 14
) (
  input  logic                                 clk,
  input  logic                                 rst,
  input  logic                                 rd,
  input  sub_sel_e                             sel,
  input  logic [NUM_OFS-1:0][DATA_W-1:0]       sub_lo,
  input  logic [NUM_OFS-1:0][OFS_W-DATA_W-1:0] sub_hi,
  output logic [DATA_W-1:0]                    rd_data,
  output logic                                 rd_valid
);

  logic [DATA_W-1:0] pick;

  always_comb begin
    unique case (sel)
      SEL_E_LO: pick = sub_lo[0];
      SEL_E_HI: pick = DATA_W'(sub_hi[0]);
      SEL_F_LO: pick = sub_lo[1];
      default:  pick = DATA_W'(sub_hi[1]);
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd;
      if (rd) rd_data <= pick;
    end
  end

endmodule

// File: rtl/offset_loader.sv
module offset_loader
  import ofsld_pkg::*;
#(
  parameter int DATA_W  = 9,
  parameter int OFS_W   = 14,
  parameter int DEF_OFS = 7
) (
  input  logic              wr_clk,
  input  logic              rd_clk,
  input  logic              rst,
  input  logic              ld,
  input  logic              wr_en_n,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en_n,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic              fifo_wr,
  output logic              fifo_rd,
  output logic [OFS_W-1:0]  empty_ofs,
  output logic [OFS_W-1:0]  full_ofs
);

  localparam int HI_W = OFS_W - DATA_W;

  logic prog_en_w, prog_en_r;
  logic reg_wr, reg_rd;
  sub_sel_e wptr, rptr;
  logic [NUM_OFS-1:0][DATA_W-1:0] sub_lo;
  logic [NUM_OFS-1:0][HI_W-1:0]   sub_hi;

  // access mode is captured only while reset is held
  always_ff @(posedge wr_clk) begin
    if (rst) prog_en_w <= ~ld;
  end

  always_ff @(posedge rd_clk) begin
    if (rst) prog_en_r <= ~ld;
  end

  assign reg_wr  = prog_en_w & ~ld & ~wr_en_n;
  assign reg_rd  = prog_en_r & ~ld & ~rd_en_n;
  assign fifo_wr = ~wr_en_n & ~reg_wr;
  assign fifo_rd = ~rd_en_n & ~reg_rd;

  ofsld_cycler u_wptr (
    .clk  (wr_clk),
    .rst  (rst),
    .step (reg_wr),
    .sel  (wptr)
  );

  ofsld_cycler u_rptr (
    .clk  (rd_clk),
    .rst  (rst),
    .step (reg_rd),
    .sel  (rptr)
  );

  ofsld_regbank #(
    .DATA_W  (DATA_W),
    .OFS_W   (OFS_W),
    .DEF_OFS (DEF_OFS)
  ) u_bank (
    .clk       (wr_clk),
    .rst       (rst),
    .wr        (reg_wr),
    .sel       (wptr),
    .din       (wr_data),
    .sub_lo    (sub_lo),
    .sub_hi    (sub_hi),
    .empty_ofs (empty_ofs),
    .full_ofs  (full_ofs)
  );

  ofsld_readback #(
    .DATA_W (DATA_W),
    .OFS_W  (OFS_W)
  ) u_rb (
    .clk      (rd_clk),
    .rst      (rst),
    .rd       (reg_rd),
    .sel      (rptr),
    .sub_lo   (sub_lo),
    .sub_hi   (sub_hi),
    .rd_data  (rd_data),
    .rd_valid (rd_valid)
  );

endmodule

// File: rtl/ofsld_checker.sv
module ofsld_checker #(
  parameter int DATA_W  = 9,
  parameter int OFS_W   = 14,
  parameter int DEF_OFS = 7
) (
  input logic              wr_clk,
  input logic              rd_clk,
  input logic              rst,
  input logic              ld,
  input logic              wr_en_n,
  input logic              rd_en_n,
  input logic [OFS_W-1:0]  empty_ofs,
  input logic [OFS_W-1:0]  full_ofs,
  input logic [DATA_W-1:0] rd_data,
  input logic              rd_valid,
  input logic [1:0]        wptr,
  input logic [1:0]        rptr,
  input logic              reg_wr,
  input logic              prog_en_w,
  input logic              prog_en_r
);

  localparam int HI_W = OFS_W - DATA_W;

  p_reset_default_r1: assert property (@(posedge wr_clk)
    rst |=> (empty_ofs == OFS_W'(DEF_OFS) && full_ofs == OFS_W'(DEF_OFS)));

  p_wrap_r3: assert property (@(posedge wr_clk) disable iff (rst)
    (reg_wr && wptr == 2'd3) |=> (wptr == 2'd0));

  p_idle_hold_r4: assert property (@(posedge wr_clk) disable iff (rst)
    (!ld && wr_en_n) |=> ($stable(empty_ofs) && $stable(full_ofs) && $stable(wptr)));

  p_fifo_write_hold_r5: assert property (@(posedge wr_clk) disable iff (rst)
    (ld && !wr_en_n) |=> ($stable(empty_ofs) && $stable(full_ofs) && $stable(wptr)));

  p_hi_zero_r6: assert property (@(posedge rd_clk) disable iff (rst)
    (rd_valid && $past(rptr[0])) |-> (rd_data[DATA_W-1:HI_W] == '0));

  p_read_pulse_r7: assert property (@(posedge rd_clk) disable iff (rst)
    (prog_en_r && !ld && !rd_en_n) |=> rd_valid);

  p_fifo_read_r8: assert property (@(posedge rd_clk) disable iff (rst)
    (ld && !rd_en_n) |=> (!rd_valid && $stable(rptr)));

  p_disabled_r9: assert property (@(posedge wr_clk) disable iff (rst)
    !prog_en_w |=> ($stable(empty_ofs) && $stable(full_ofs)));

endmodule

bind offset_loader ofsld_checker #(
  .DATA_W  (DATA_W),
  .OFS_W   (OFS_W),
  .DEF_OFS (DEF_OFS)
) u_chk (
  .wr_clk    (wr_clk),
  .rd_clk    (rd_clk),
  .rst       (rst),
  .ld        (ld),
  .wr_en_n   (wr_en_n),
  .rd_en_n   (rd_en_n),
  .empty_ofs (empty_ofs),
  .full_ofs  (full_ofs),
  .rd_data   (rd_data),
  .rd_valid  (rd_valid),
  .wptr      (wptr),
  .rptr      (rptr),
  .reg_wr    (reg_wr),
  .prog_en_w (prog_en_w),
  .prog_en_r (prog_en_r)
);

// File: tb/offset_loader_bench.sv
module offset_loader_bench;

  localparam int DATA_W = 9;
  localparam int OFS_W  = 14;
  localparam int HI_W   = OFS_W - DATA_W;

  logic              wr_clk = 1'b0;
  logic              rd_clk = 1'b0;
  logic              rst = 1'b1;
  logic              ld = 1'b0;
  logic              wr_en_n = 1'b1;
  logic [DATA_W-1:0] wr_data = '0;
  logic              rd_en_n = 1'b1;
  logic [DATA_W-1:0] rd_data;
  logic              rd_valid;
  logic              fifo_wr, fifo_rd;
  logic [OFS_W-1:0]  empty_ofs, full_ofs;

  int checks = 0;
  int fails  = 0;

  logic [DATA_W-1:0] m_sub [4];
  int m_wp = 0;
  int m_rp = 0;

  always #10 wr_clk = ~wr_clk;
  initial begin
    #5;
    forever #10 rd_clk = ~rd_clk;
  end

  offset_loader u_offset_loader (
    .wr_clk    (wr_clk),
    .rd_clk    (rd_clk),
    .rst       (rst),
    .ld        (ld),
    .wr_en_n   (wr_en_n),
    .wr_data   (wr_data),
    .rd_en_n   (rd_en_n),
    .rd_data   (rd_data),
    .rd_valid  (rd_valid),
    .fifo_wr   (fifo_wr),
    .fifo_rd   (fifo_rd),
    .empty_ofs (empty_ofs),
    .full_ofs  (full_ofs)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [OFS_W-1:0] exp_ofs(input int idx);
    return {m_sub[2*idx+1][HI_W-1:0], m_sub[2*idx]};
  endfunction

  task automatic model_reset();
    for (int i = 0; i < 4; i++) m_sub[i] = (i % 2 == 0) ? DATA_W'(7) : '0;
    m_wp = 0;
    m_rp = 0;
  endtask

  task automatic do_reset(input logic ld_at_reset);
    @(negedge wr_clk);
    rst = 1'b1; ld = ld_at_reset; wr_en_n = 1'b1; rd_en_n = 1'b1;
    repeat (3) @(negedge wr_clk);
    rst = 1'b0; ld = 1'b0;
    model_reset();
  endtask

  task automatic reg_write(input logic [DATA_W-1:0] d, input string req);
    @(negedge wr_clk);
    ld = 1'b0; wr_en_n = 1'b0; wr_data = d;
    @(negedge wr_clk);
    wr_en_n = 1'b1;
    m_sub[m_wp] = (m_wp % 2 == 1) ? DATA_W'(d[HI_W-1:0]) : d;
    m_wp = (m_wp + 1) % 4;
    check(req, 32'(empty_ofs), 32'(exp_ofs(0)));
    check(req, 32'(full_ofs), 32'(exp_ofs(1)));
  endtask

  task automatic reg_read(input string req);
    @(negedge rd_clk);
    ld = 1'b0; rd_en_n = 1'b0;
    @(negedge rd_clk);
    rd_en_n = 1'b1;
    check(req, 32'(rd_valid), 32'd1);
    check(req, 32'(rd_data), 32'(m_sub[m_rp]));
    m_rp = (m_rp + 1) % 4;
  endtask

  task automatic t_reset_r1();
    do_reset(1'b0);
    check("R1", 32'(empty_ofs), 32'd7);
    check("R1", 32'(full_ofs), 32'd7);
    check("R1", 32'(rd_data), 32'd0);
    check("R1", 32'(rd_valid), 32'd0);
  endtask

  task automatic t_order_r2();
    reg_write(9'h1A5, "R2");
    reg_write(9'h1F3, "R2 R6");
    reg_write(9'h0C2, "R2");
    reg_write(9'h0E8, "R2 R6");
    check("R2", 32'(empty_ofs), 32'h27A5);
    check("R2", 32'(full_ofs), 32'h10C2);
  endtask

  task automatic t_wrap_r3();
    reg_write(9'h055, "R3");
    check("R3", 32'(empty_ofs[DATA_W-1:0]), 32'h055);
  endtask

  task automatic t_idle_r4();
    logic [OFS_W-1:0] e0, f0;
    e0 = empty_ofs; f0 = full_ofs;
    @(negedge wr_clk);
    ld = 1'b0; wr_en_n = 1'b1; wr_data = 9'h1FF;
    repeat (3) @(negedge wr_clk);
    check("R4", 32'(empty_ofs), 32'(e0));
    check("R4", 32'(full_ofs), 32'(f0));
    reg_write(9'h1EA, "R4 pointer held");
  endtask

  task automatic t_fifo_write_r5();
    logic [OFS_W-1:0] e0, f0;
    e0 = empty_ofs; f0 = full_ofs;
    @(negedge wr_clk);
    ld = 1'b1; wr_en_n = 1'b0; wr_data = 9'h133;
    #1 check("R5", 32'(fifo_wr), 32'd1);
    @(negedge wr_clk);
    wr_en_n = 1'b1; ld = 1'b0;
    #1 check("R5", 32'(fifo_wr), 32'd0);
    check("R5", 32'(empty_ofs), 32'(e0));
    check("R5", 32'(full_ofs), 32'(f0));
    reg_write(9'h0A1, "R5 pointer held");
    reg_write(9'h1FC, "R5 R6");
  endtask

  task automatic t_readback_r7();
    for (int i = 0; i < 5; i++) reg_read("R7");
    check("R6", 32'(m_sub[1] >> HI_W), 32'd0);
  endtask

  task automatic t_fifo_read_r8();
    @(negedge rd_clk);
    ld = 1'b1; rd_en_n = 1'b0;
    #1 check("R8", 32'(fifo_rd), 32'd1);
    @(negedge rd_clk);
    rd_en_n = 1'b1; ld = 1'b0;
    check("R8", 32'(rd_valid), 32'd0);
    reg_read("R8 pointer held");
  endtask

  task automatic t_midreset_r10();
    reg_write(9'h0F0, "R10");
    reg_write(9'h1C3, "R10");
    reg_read("R10");
    do_reset(1'b0);
    check("R10", 32'(empty_ofs), 32'd7);
    check("R10", 32'(full_ofs), 32'd7);
    reg_write(9'h0AB, "R10 restart");
    check("R10", 32'(empty_ofs[DATA_W-1:0]), 32'h0AB);
    reg_read("R10 restart");
  endtask

  task automatic t_disabled_r9();
    do_reset(1'b1);
    @(negedge wr_clk);
    ld = 1'b0; wr_en_n = 1'b0; wr_data = 9'h155;
    #1 check("R9", 32'(fifo_wr), 32'd1);
    repeat (2) @(negedge wr_clk);
    wr_en_n = 1'b1;
    check("R9", 32'(empty_ofs), 32'd7);
    check("R9", 32'(full_ofs), 32'd7);
    @(negedge rd_clk);
    ld = 1'b0; rd_en_n = 1'b0;
    #1 check("R9", 32'(fifo_rd), 32'd1);
    @(negedge rd_clk);
    rd_en_n = 1'b1;
    check("R9", 32'(rd_valid), 32'd0);
  endtask

  initial begin
    model_reset();
    t_reset_r1();
    t_order_r2();
    t_wrap_r3();
    t_idle_r4();
    t_fifo_write_r5();
    t_readback_r7();
    t_fifo_read_r8();
    t_midreset_r10();
    t_disabled_r9();
    repeat (2) @(negedge wr_clk);
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge wr_clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule